// File: doc/BRIEF.md
# BCD Calendar Clock Counter

This block keeps the time of day and the calendar in packed BCD. An external one-second pulse advances it. The block holds seconds, minutes, hours in 24-hour form, day of week, day of month, month and a two-digit year. A century flag sits in the hours byte and can be armed or disarmed. When it is armed, the flag inverts each time the year wraps from 99 to 00.

A halt flag in the seconds byte freezes timekeeping while it is set. A synchronous write port loads any byte in a single cycle. A write to a byte takes precedence over the advance of that byte in the same cycle. All seven bytes are always visible on dedicated outputs. Bits that a byte does not use read as zero.

Top module: `bcd_calendar_clock`

## Requirements
- R1: After reset the outputs are seconds 8'h00 (halt clear), minutes 8'h00, hours 8'h00 (century flags clear), day of week 8'h01, date 8'h01, month 8'h01 and year 8'h00.
- R2: Each tick raises the seconds by one in BCD. At 59 the seconds go to 00 and the minutes rise by one. Minutes wrap from 59 to 00 the same way and carry into the hours.
- R3: Hours run from 00 to 23. A wrap from 23 to 00 (midnight) advances both the day of week and the date.
- R4: At midnight the day of week counts 1 to 7 and then returns to 1. Its outputs in bits 7:3 are always zero.
- R5: The date wraps to 01 and the month advances after day 30 in months 04, 06, 09 and 11, and after day 31 in the other months except 02.
- R6: In month 02 the date wraps after day 29 when the year value is divisible by 4, with 00 counting as divisible. In all other years it wraps after day 28.
- R7: The month wraps from 12 to 01 and carries into the year. The year wraps from 99 to 00.
- R8: Hours bit 7 is the century arm flag and bit 6 is the century flag. When the year wraps from 99 to 00 with the arm flag at 1, the century flag inverts. With the arm flag at 0, the century flag never changes on its own.
- R9: Seconds bit 7 is the halt flag. While it reads 1, ticks are ignored. A tick in the same cycle as the write that clears it also has no effect. The first advance comes on the next tick after that.
- R10: Write addresses are 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 date, 5 month and 6 year. A write keeps only the used bits: minutes 6:0, hours 7:0, day of week 2:0, date 5:0, month 4:0, year 7:0 and seconds 7:0. Writes to address 7 change nothing.
- R11: A write and a tick in the same cycle load the written byte with the write data. The other bytes advance from their old values.
- R12: In cycles with neither a tick nor a write, every output holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle pulse, one per second |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 3 | Byte select for the write |
| wr_data | input | 8 | Write data |
| sec_o | output | 8 | Halt flag and BCD seconds |
| min_o | output | 8 | BCD minutes |
| hour_o | output | 8 | Century arm, century flag and BCD hours |
| dow_o | output | 8 | Day of week, 1 to 7 |
| date_o | output | 8 | BCD day of month |
| month_o | output | 8 | BCD month |
| year_o | output | 8 | BCD year |

## Verification
The assertions check several behaviours on every cycle:
- the seconds wrap at 59;
- the day of week returns to 1 at the midnight after day 7;
- all counting freezes while halted;
- the century flag holds while disarmed;
- a minutes write wins over its advance;
- all outputs hold when the cycle is idle.

Only the bench scenarios can show the month-length and leap-year boundaries, the year and century rollover, and the masking of unused written bits. The same applies to the exact tick on which counting resumes after a halt. Each of these needs a chosen calendar state that the bench loads through the write port before the decisive tick.

// File: rtl/bcd_calendar_clock.sv
`timescale 1ns/1ps
module bcd_calendar_clock (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       wr_en,
  input  logic [2:0] wr_addr,
  input  logic [7:0] wr_data,
  output logic [7:0] sec_o,
  output logic [7:0] min_o,
  output logic [7:0] hour_o,
  output logic [7:0] dow_o,
  output logic [7:0] date_o,
  output logic [7:0] month_o,
  output logic [7:0] year_o
);

  logic       halt, cen_en, cen;
  logic [7:0] sec, mins, hrs, dow, date, mon, yr;
  logic [7:0] last_day;
  logic [6:0] yr_bin;
  logic       adv, c_min, c_hr, c_day, c_mon, c_yr, c_cen;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    bcd_inc = (v[3:0] == 4'd9) ? {v[7:4] + 4'd1, 4'd0} : {v[7:4], v[3:0] + 4'd1};
  endfunction

  assign yr_bin = {3'b0, yr[7:4]} * 7'd10 + {3'b0, yr[3:0]};

  always_comb begin
    case (mon)
      8'h02:                      last_day = (yr_bin[1:0] == 2'b00) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: last_day = 8'h30;
      default:                    last_day = 8'h31;
    endcase
  end

  assign adv   = tick & ~halt;
  assign c_min = adv   & (sec  == 8'h59);
  assign c_hr  = c_min & (mins == 8'h59);
  assign c_day = c_hr  & (hrs  == 8'h23);
  assign c_mon = c_day & (date == last_day);
  assign c_yr  = c_mon & (mon  == 8'h12);
  assign c_cen = c_yr  & (yr   == 8'h99);

  function automatic logic hit(input logic [2:0] a);
    hit = wr_en && (wr_addr == a);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halt <= 1'b0; cen_en <= 1'b0; cen <= 1'b0;
      sec <= 8'h00; mins <= 8'h00; hrs <= 8'h00; dow <= 8'h01;
      date <= 8'h01; mon <= 8'h01; yr <= 8'h00;
    end else begin
      if (hit(3'd0)) begin
        halt <= wr_data[7];
        sec  <= {1'b0, wr_data[6:0]};
      end else if (adv)
        sec <= (sec == 8'h59) ? 8'h00 : bcd_inc(sec);

      if (hit(3'd1))  mins <= {1'b0, wr_data[6:0]};
      else if (c_min) mins <= (mins == 8'h59) ? 8'h00 : bcd_inc(mins);

      if (hit(3'd2)) begin
        cen_en <= wr_data[7];
        cen    <= wr_data[6];
        hrs    <= {2'b0, wr_data[5:0]};
      end else begin
        if (c_hr)           hrs <= (hrs == 8'h23) ? 8'h00 : bcd_inc(hrs);
        if (c_cen & cen_en) cen <= ~cen;
      end

      if (hit(3'd3))  dow <= {5'b0, wr_data[2:0]};
      else if (c_day) dow <= (dow == 8'h07) ? 8'h01 : dow + 8'h01;

      if (hit(3'd4))  date <= {2'b0, wr_data[5:0]};
      else if (c_day) date <= (date == last_day) ? 8'h01 : bcd_inc(date);

      if (hit(3'd5))  mon <= {3'b0, wr_data[4:0]};
      else if (c_mon) mon <= (mon == 8'h12) ? 8'h01 : bcd_inc(mon);

      if (hit(3'd6))  yr <= wr_data;
      else if (c_yr)  yr <= (yr == 8'h99) ? 8'h00 : bcd_inc(yr);
    end
  end

  assign sec_o   = sec | {halt, 7'b0};
  assign min_o   = mins;
  assign hour_o  = hrs | {cen_en, cen, 6'b0};
  assign dow_o   = dow;
  assign date_o  = date;
  assign month_o = mon;
  assign year_o  = yr;

  assert_sec_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !halt && !wr_en && sec_o == 8'h59) |=> (sec_o == 8'h00));

  assert_dow_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !halt && !wr_en && sec_o == 8'h59 && min_o == 8'h59 &&
     hour_o[5:0] == 6'h23 && dow_o == 8'h07) |=> (dow_o == 8'h01));

  assert_halt_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_o[7] && !wr_en) |=> $stable({sec_o, min_o, hour_o, dow_o, date_o, month_o, year_o}));

  assert_cen_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!hour_o[7] && !wr_en) |=> $stable(hour_o[6]));

  assert_write_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 3'd1) |=> (min_o == {1'b0, $past(wr_data[6:0])}));

  assert_idle_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_en) |=> $stable({sec_o, min_o, hour_o, dow_o, date_o, month_o, year_o}));

endmodule

// File: tb/bcd_calendar_clock_tb.sv
`timescale 1ns/1ps
module bcd_calendar_clock_tb;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, wr_en = 1'b0;
  logic [2:0] wr_addr = 3'd0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] sec_o, min_o, hour_o, dow_o, date_o, month_o, year_o;

  bcd_calendar_clock u_dut (.clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o),
    .dow_o(dow_o), .date_o(date_o), .month_o(month_o), .year_o(year_o));

  always #4 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [55:0] exp_q[$];
  string tag_q[$];

  int m_sec = 0, m_min = 0, m_hr = 0, m_dow = 1, m_date = 1, m_mon = 1, m_yr = 0;
  bit m_stop = 0, m_cen = 0, m_cen_en = 0;

  function automatic logic [7:0] to_bcd(int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction
  function automatic int from_bcd(logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction
  function automatic int days_in(int mo, int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  task automatic model_tick();
    if (m_stop) return;
    m_sec++;
    if (m_sec < 60) return;
    m_sec = 0; m_min++;
    if (m_min < 60) return;
    m_min = 0; m_hr++;
    if (m_hr < 24) return;
    m_hr = 0; m_dow = (m_dow == 7) ? 1 : m_dow + 1; m_date++;
    if (m_date <= days_in(m_mon, m_yr)) return;
    m_date = 1; m_mon++;
    if (m_mon < 13) return;
    m_mon = 1; m_yr++;
    if (m_yr < 100) return;
    m_yr = 0;
    if (m_cen_en) m_cen = ~m_cen;
  endtask

  task automatic model_write(logic [2:0] a, logic [7:0] d);
    case (a)
      3'd0: begin m_stop = d[7]; m_sec = from_bcd({1'b0, d[6:0]}); end
      3'd1: m_min = from_bcd({1'b0, d[6:0]});
      3'd2: begin m_cen_en = d[7]; m_cen = d[6]; m_hr = from_bcd({2'b0, d[5:0]}); end
      3'd3: m_dow = int'(d[2:0]);
      3'd4: m_date = from_bcd({2'b0, d[5:0]});
      3'd5: m_mon = from_bcd({3'b0, d[4:0]});
      3'd6: m_yr = from_bcd(d);
      default: ;
    endcase
  endtask

  function automatic logic [55:0] pack();
    logic [7:0] s, h;
    s = to_bcd(m_sec) | {m_stop, 7'b0};
    h = to_bcd(m_hr) | {m_cen_en, m_cen, 6'b0};
    return {s, to_bcd(m_min), h, to_bcd(m_dow), to_bcd(m_date), to_bcd(m_mon), to_bcd(m_yr)};
  endfunction

  task automatic step(bit t, bit w, logic [2:0] a, logic [7:0] d, string tag);
    @(negedge clk);
    tick = t; wr_en = w; wr_addr = a; wr_data = d;
    if (t) model_tick();
    if (w) model_write(a, d);
    exp_q.push_back(pack());
    tag_q.push_back(tag);
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d, string tag); step(0, 1, a, d, tag); endtask
  task automatic tk(string tag); step(1, 0, 3'd0, 8'h00, tag); endtask
  task automatic idle(string tag); step(0, 0, 3'd0, 8'h00, tag); endtask
  task automatic set_cal(logic [7:0] s, logic [7:0] mi, logic [7:0] h, logic [7:0] dw,
                         logic [7:0] dt, logic [7:0] mo, logic [7:0] y, string tag);
    wr(3'd0, s, tag); wr(3'd1, mi, tag); wr(3'd2, h, tag); wr(3'd3, dw, tag);
    wr(3'd4, dt, tag); wr(3'd5, mo, tag); wr(3'd6, y, tag);
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk); #2;
      if (exp_q.size() > 0) begin
        logic [55:0] e, act;
        string t;
        e = exp_q.pop_front(); t = tag_q.pop_front();
        act = {sec_o, min_o, hour_o, dow_o, date_o, month_o, year_o};
        n_chk++;
        if (act !== e) begin
          n_fail++;
          $display("FAIL %s: actual %h expected %h", t, act, e);
        end
      end
    end
  end

  initial begin : watchdog
    #(8 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle("R1 reset state");
    wr(3'd0, 8'h58, "R10"); tk("R2 sec 59"); tk("R2 sec wrap to minute");
    set_cal(8'h59, 8'h59, 8'h12, 8'h03, 8'h10, 8'h07, 8'h20, "R10");
    tk("R2 minute carry into hour");
    set_cal(8'h59, 8'h59, 8'h23, 8'h03, 8'h10, 8'h07, 8'h20, "R10");
    tk("R3 midnight advances day and date");
    set_cal(8'h59, 8'h59, 8'h23, 8'h07, 8'h15, 8'h07, 8'h20, "R10");
    tk("R4 day of week 7 to 1");
    set_cal(8'h59, 8'h59, 8'h23, 8'h02, 8'h30, 8'h04, 8'h20, "R10");
    tk("R5 30-day month wrap");
    set_cal(8'h59, 8'h59, 8'h23, 8'h02, 8'h30, 8'h05, 8'h20, "R10");
    tk("R5 31-day month reaches 31");
    set_cal(8'h59, 8'h59, 8'h23, 8'h02, 8'h31, 8'h05, 8'h20, "R10");
    tk("R5 31-day month wrap");
    set_cal(8'h59, 8'h59, 8'h23, 8'h02, 8'h28, 8'h02, 8'h23, "R10");
    tk("R6 common year Feb 28 wrap");
    set_cal(8'h59, 8'h59, 8'h23, 8'h02, 8'h28, 8'h02, 8'h24, "R10");
    tk("R6 leap year Feb 29");
    set_cal(8'h59, 8'h59, 8'h23, 8'h02, 8'h28, 8'h02, 8'h00, "R10");
    tk("R6 year 00 Feb 29");
    set_cal(8'h59, 8'h59, 8'h23, 8'h02, 8'h29, 8'h02, 8'h00, "R10");
    tk("R6 leap Feb 29 wrap");
    set_cal(8'h59, 8'h59, 8'h23, 8'h02, 8'h31, 8'h12, 8'h41, "R10");
    tk("R7 December wrap into year");
    set_cal(8'h59, 8'h59, 8'hA3, 8'h02, 8'h31, 8'h12, 8'h99, "R10");
    tk("R8 armed century flips");
    set_cal(8'h59, 8'h59, 8'h63, 8'h02, 8'h31, 8'h12, 8'h99, "R10");
    tk("R8 disarmed century holds");
    wr(3'd0, 8'h90, "R9 set halt");
    tk("R9 halted tick"); tk("R9 halted tick"); idle("R9 halted idle");
    step(1, 1, 3'd0, 8'h10, "R9 clear with tick no advance");
    tk("R9 resume on next tick");
    wr(3'd7, 8'h55, "R10 address 7 ignored");
    wr(3'd1, 8'hB0, "R10 minutes bit 7 dropped");
    wr(3'd3, 8'hFD, "R10 day of week bits 7:3 zero");
    wr(3'd4, 8'hC5, "R10 date bits 7:6 zero");
    wr(3'd5, 8'hE9, "R10 month bits 7:5 zero");
    wr(3'd0, 8'h59, "R10"); wr(3'd1, 8'h10, "R10");
    step(1, 1, 3'd1, 8'h30, "R11 minute write beats carry");
    wr(3'd0, 8'h05, "R10");
    step(1, 1, 3'd0, 8'h40, "R11 seconds write beats tick");
    idle("R12 idle hold"); idle("R12 idle hold"); idle("R12 idle hold");
    repeat (3) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule